// File: doc/BRIEF.md
# Sensor Minimum/Maximum Tracker

This block keeps a running highest and lowest reading for each on-chip sensor channel: die temperature, core supply, auxiliary supply, block-RAM supply and, when the processor-side option is built, three more supplies. The processor-side three are the processor core, the processor auxiliary and the memory I/O supply. A measurement arrives as a one-cycle strobe that carries a channel index and a 16-bit result. Each result is compared with both tracked values of its channel in that same cycle.

The tracked values are read-only. A read port with an address, an enable and a ready pulse exposes them in a 16-word window at 20h..2Fh. Maxima and minima alternate in groups of four. Slots that are unassigned or removed read as zero. A parameter removes the three processor-side channels entirely.

Top module: `sensor_extreme_regs`

## Requirements
- R1: After reset every maximum reads 0000h, every minimum reads FFFFh and rd_rdy is 0.
- R2: A measurement replaces its channel's maximum only when it is strictly greater than the stored maximum.
- R3: A measurement replaces its channel's minimum only when it is strictly less than the stored minimum.
- R4: The compare-and-update happens at the clock edge that samples meas_vld. The first result after reset therefore sets both the maximum and the minimum, unless it equals the reset value of that register.
- R5: Channel indices 0 (temperature), 1 (core), 2 (auxiliary) and 3 (block RAM) have their maxima at 20h+index and their minima at 24h+index.
- R6: Channel indices 4, 5 and 6 (processor core, processor auxiliary, memory I/O) have their maxima at 28h..2Ah and their minima at 2Ch..2Eh. Addresses 2Bh and 2Fh always read 0000h.
- R7: With HAS_PROC_CH=0, measurements for channels 4..6 are ignored and addresses 28h..2Ah and 2Ch..2Eh read 0000h.
- R8: rd_rdy is high for exactly the cycle after a cycle with rd_en high, and rd_data carries the read value in that cycle. Addresses outside 20h..2Fh read 0000h.
- R9: A read and a measurement that change the same register in the same cycle return the value from before the update.
- R10: A measurement with channel index 7 changes no tracked value.
- R11: Comparisons are unsigned 16-bit, so 8000h is greater than 7FFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_vld | input | 1 | Measurement strobe |
| meas_chan | input | 3 | Channel index of the measurement |
| meas_data | input | 16 | Measurement result, unsigned |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read address |
| rd_rdy | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 16 | Read data |

## Verification
A measurement takes effect at the edge that samples it, so a read issued in the following cycle already sees the new value. Read data comes out one edge after rd_en. The bench therefore drives each request just after a rising edge and samples rd_rdy and rd_data 1 ns after the next edge. It computes the expected value from its model before it applies any measurement that shares that edge, which is the ordering R9 requires. Instances with and without the processor-side channels run side by side on the same stimulus.

// File: rtl/sxt_pkg.sv
package sxt_pkg;
   localparam int unsigned SLOT_CNT = 8;
   localparam int unsigned SLOT_W   = 3;

   // window offset -> tracked channel slot: bit3 selects the bank of four,
   // bit2 selects max (0) or min (1), bits1:0 select the channel inside the bank
   function automatic logic [SLOT_W-1:0] slot_of(input logic [3:0] off);
      return {off[3], off[1:0]};
   endfunction

   function automatic logic is_min_of(input logic [3:0] off);
      return off[2];
   endfunction
endpackage

// File: rtl/sxt_track_cell.sv
module sxt_track_cell #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [DATA_W-1:0] val,
   output logic [DATA_W-1:0] max_o,
   output logic [DATA_W-1:0] min_o
);
   localparam logic [DATA_W-1:0] MAX_INIT = '0;
   localparam logic [DATA_W-1:0] MIN_INIT = '1;

   logic [DATA_W-1:0] max_q, min_q;
   logic              raise_max, lower_min;

   if (DATA_W < 2) begin : g_bad_width
      $error("sxt_track_cell: DATA_W must be at least 2");
   end

   always_comb begin
      raise_max = upd && (val > max_q);
      lower_min = upd && (val < min_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         max_q <= MAX_INIT;
         min_q <= MIN_INIT;
      end else begin
         if (raise_max) max_q <= val;
         if (lower_min) min_q <= val;
      end
   end

   assign max_o = max_q;
   assign min_o = min_q;

   assert_max_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && val > max_o) |=> (max_o == $past(val)));
   assert_max_never_falls_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd && val > max_o) |=> $stable(max_o));
   assert_min_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && val < min_o) |=> (min_o == $past(val)));
   assert_min_never_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd && val < min_o) |=> $stable(min_o));
endmodule

// File: rtl/sxt_read_port.sv
module sxt_read_port
   import sxt_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BASE_ADDR = 'h20,
   parameter int unsigned NUM_CH    = 7
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             rd_en,
   input  logic [ADDR_W-1:0]                rd_addr,
   input  logic [SLOT_CNT-1:0][DATA_W-1:0]  max_bus,
   input  logic [SLOT_CNT-1:0][DATA_W-1:0]  min_bus,
   output logic                             rd_rdy,
   output logic [DATA_W-1:0]                rd_data
);
   localparam logic [ADDR_W-1:0] BASE    = ADDR_W'(BASE_ADDR);
   localparam logic [SLOT_W:0]   CH_LIM  = (SLOT_W+1)'(NUM_CH);

   if (BASE_ADDR % 16 != 0) begin : g_bad_base
      $error("sxt_read_port: BASE_ADDR must be 16-word aligned");
   end
   if (NUM_CH > SLOT_CNT - 1) begin : g_bad_ch
      $error("sxt_read_port: NUM_CH exceeds the assigned slots");
   end

   logic              in_win, hit;
   logic [3:0]        off;
   logic [SLOT_W-1:0] slot;
   logic [DATA_W-1:0] sel;

   always_comb begin
      in_win = (rd_addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
      off    = rd_addr[3:0];
      slot   = slot_of(off);
      hit    = in_win && ({1'b0, slot} < CH_LIM);
      sel    = '0;
      if (hit) sel = is_min_of(off) ? min_bus[slot] : max_bus[slot];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_rdy  <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_rdy  <= rd_en;
         rd_data <= rd_en ? sel : '0;
      end
   end

   assert_rdy_after_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_rdy);
   assert_rdy_only_after_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_rdy);
   assert_outside_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !in_win) |=> (rd_data == '0));
   assert_hole_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && in_win && off[1:0] == 2'b11 && off[3]) |=> (rd_data == '0));
endmodule

// File: rtl/sensor_extreme_regs.sv
module sensor_extreme_regs
   import sxt_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned BASE_ADDR   = 'h20,
   parameter bit          HAS_PROC_CH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              meas_vld,
   input  logic [2:0]        meas_chan,
   input  logic [15:0]       meas_data,
   input  logic              rd_en,
   input  logic [7:0]        rd_addr,
   output logic              rd_rdy,
   output logic [15:0]       rd_data
);
   localparam int unsigned NUM_CH = HAS_PROC_CH ? 7 : 4;
   localparam logic [SLOT_W:0] CH_LIM = (SLOT_W+1)'(NUM_CH);

   if (DATA_W != 16 || ADDR_W != 8) begin : g_bad_port
      $error("sensor_extreme_regs: port widths are fixed at 16-bit data, 8-bit address");
   end

   logic                            meas_hit;
   logic [SLOT_CNT-1:0][DATA_W-1:0] max_bus, min_bus;

   assign meas_hit = meas_vld && ({1'b0, meas_chan} < CH_LIM);

   for (genvar i = 0; i < SLOT_CNT; i++) begin : g_slot
      if (i < NUM_CH) begin : g_live
         sxt_track_cell #(.DATA_W(DATA_W)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .upd   (meas_hit && (meas_chan == SLOT_W'(i))),
            .val   (meas_data),
            .max_o (max_bus[i]),
            .min_o (min_bus[i])
         );
      end else begin : g_absent
         assign max_bus[i] = '0;
         assign min_bus[i] = '0;
      end
   end

   sxt_read_port #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .NUM_CH    (NUM_CH)
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .max_bus (max_bus),
      .min_bus (min_bus),
      .rd_rdy  (rd_rdy),
      .rd_data (rd_data)
   );

   // R10 and R7: strobes for untracked channels leave every register alone
   assert_untracked_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_vld && !meas_hit) |=> ($stable(max_bus) && $stable(min_bus)));
   assert_idle_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_vld |=> ($stable(max_bus) && $stable(min_bus)));
endmodule

// File: tb/tb_sensor_extreme_regs.sv
`timescale 1ns/1ps
module tb_sensor_extreme_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        meas_vld = 1'b0;
   logic [2:0]  meas_chan = '0;
   logic [15:0] meas_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic        rdy1, rdy0;
   logic [15:0] dat1, dat0;

   int errors = 0;
   int checks = 0;
   logic [15:0] mx [8];
   logic [15:0] mn [8];

   always #2 clk = ~clk;

   sensor_extreme_regs #(.HAS_PROC_CH(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld), .meas_chan(meas_chan),
      .meas_data(meas_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_rdy(rdy1), .rd_data(dat1));

   sensor_extreme_regs #(.HAS_PROC_CH(1'b0)) dut_lite (
      .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld), .meas_chan(meas_chan),
      .meas_data(meas_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_rdy(rdy0), .rd_data(dat0));

   function automatic logic [15:0] expv(input logic [7:0] a, input bit proc);
      logic [2:0] s;
      if (a[7:4] != 4'h2) return 16'h0;
      s = {a[3], a[1:0]};
      if (s == 3'd7 || (!proc && s >= 3'd4)) return 16'h0;
      return a[2] ? mn[s] : mx[s];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_meas(input logic [2:0] c, input logic [15:0] d);
      if (c != 3'd7) begin
         if (d > mx[c]) mx[c] = d;
         if (d < mn[c]) mn[c] = d;
      end
   endtask

   // one cycle: optional measurement, optional read; results sampled 1 ns after the edge
   task automatic cyc(input bit mv, input logic [2:0] c, input logic [15:0] d,
                      input bit rv, input logic [7:0] a, input string tag);
      logic [15:0] e1, e0;
      e1 = expv(a, 1'b1);
      e0 = expv(a, 1'b0);
      meas_vld = mv; meas_chan = c; meas_data = d;
      rd_en = rv; rd_addr = a;
      @(posedge clk); #1;
      meas_vld = 1'b0; rd_en = 1'b0;
      if (mv) model_meas(c, d);
      chk({tag, " rdy"}, {31'b0, rdy1}, {31'b0, rv});
      chk({tag, " rdy lite"}, {31'b0, rdy0}, {31'b0, rv});
      if (rv) begin
         chk(tag, {16'b0, dat1}, {16'b0, e1});
         chk({tag, " lite"}, {16'b0, dat0}, {16'b0, e0});
      end
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      cyc(1'b0, 3'd0, 16'h0, 1'b1, a, tag);
   endtask

   task automatic ms(input logic [2:0] c, input logic [15:0] d, input string tag);
      cyc(1'b1, c, d, 1'b0, 8'h00, tag);
   endtask

   task automatic read_window(input string tag);
      for (int a = 'h20; a <= 'h2F; a++) rd(8'(a), tag);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'h5EED_0042;
      void'($urandom(seed));
      for (int i = 0; i < 8; i++) begin mx[i] = 16'h0000; mn[i] = 16'hFFFF; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk("R1 rdy after reset", {31'b0, rdy1}, 32'd0);
      read_window("R1 R5 R6 R7 reset values");

      ms(3'd0, 16'h1234, "R4 first");
      rd(8'h20, "R4 first max"); rd(8'h24, "R4 first min");
      ms(3'd0, 16'h1234, "R2 equal");
      rd(8'h20, "R2 equal keeps max"); rd(8'h24, "R3 equal keeps min");
      ms(3'd0, 16'h2000, "R2 higher");
      rd(8'h20, "R2 higher max"); rd(8'h24, "R3 higher leaves min");
      ms(3'd0, 16'h1000, "R3 lower");
      rd(8'h20, "R2 lower leaves max"); rd(8'h24, "R3 lower min");

      ms(3'd1, 16'h7FFF, "R11 a"); ms(3'd1, 16'h8000, "R11 b");
      rd(8'h21, "R11 unsigned max"); rd(8'h25, "R11 unsigned min");

      ms(3'd3, 16'h0000, "R4 zero first");
      rd(8'h23, "R4 zero keeps max"); rd(8'h27, "R4 zero sets min");
      ms(3'd2, 16'hFFFF, "R4 ffff first");
      rd(8'h22, "R4 ffff sets max"); rd(8'h26, "R4 ffff keeps min");

      ms(3'd7, 16'hFFFF, "R10 a"); ms(3'd7, 16'h0001, "R10 b");
      read_window("R10 ignored channel");

      ms(3'd5, 16'h0ABC, "R7 proc");
      ms(3'd4, 16'h0111, "R6 proc");
      ms(3'd6, 16'hF00D, "R6 proc");
      read_window("R6 R7 proc channels");

      cyc(1'b1, 3'd0, 16'hFFF0, 1'b1, 8'h20, "R9 same-cycle max");
      rd(8'h20, "R9 after update");
      cyc(1'b1, 3'd1, 16'h0002, 1'b1, 8'h25, "R9 same-cycle min");
      rd(8'h25, "R9 after update min");

      rd(8'h1F, "R8 below window"); rd(8'h30, "R8 above window");
      rd(8'hA4, "R8 far address"); rd(8'h2B, "R6 hole"); rd(8'h2F, "R6 hole");
      @(posedge clk); #1;
      chk("R8 no rdy when idle", {31'b0, rdy1}, 32'd0);

      for (int n = 0; n < 600; n++) begin
         logic [15:0] d;
         logic [2:0]  c;
         int unsigned sel;
         sel = $urandom_range(0, 9);
         d = (sel == 0) ? 16'h0000 : (sel == 1) ? 16'hFFFF : 16'($urandom);
         c = 3'($urandom_range(0, 7));
         cyc(($urandom_range(0, 3) != 0), c, d, ($urandom_range(0, 2) != 0),
             (sel < 8) ? 8'(8'h20 + $urandom_range(0, 15)) : 8'($urandom),
             "R2 R3 R8 random");
      end
      read_window("R5 R6 final sweep");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule